// File: doc/BRIEF.md
# Thermal Clock-Limit Governor

This block keeps a clock multiplier and a ceiling for that multiplier (the "cool max") in step with the die temperature. Each accepted temperature sample is sorted into one of three bands around a target: above target plus hysteresis, below target minus hysteresis, or just below target. A hot sample cuts the multiplier by one step and pulls the ceiling down to the new multiplier. Only one such cut is allowed per one-second interval, and the `sec_tick` pulse marks where each interval starts. A cold sample restores the ceiling to the absolute maximum. A sample just below target lets the ceiling creep up one step, and only when the multiplier is already sitting at the ceiling. The output frequency is twice the multiplier.

Other logic, such as error-rate tuning, asks for a new multiplier through the request port. The block clamps each request into the range from the minimum to the present ceiling. Whenever the multiplier value changes, a one-cycle strobe tells the clock-programming logic to reload.

Temperature samples use a valid/ready handshake. `t_ready` is high in every cycle outside reset, so a sample is taken in any cycle where `t_valid` is high and the source never sees back-pressure. A sample of zero means the reading is invalid and is discarded.

Top module: `thermal_gov`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `mult` equals DEF_MULT, `ceil_m` equals RST_CEIL and `mult_chg` is 0.
- R2: An accepted sample with t_data > target + hyst, when a cut is allowed, sets `mult` to mult-1 and `ceil_m` to that new value, both visible after the next clock edge.
- R3: At most one thermal cut is applied per interval. An interval starts at each cycle with `sec_tick` high. A hot sample in the same cycle as `sec_tick` belongs to the new interval. A hot sample that is not allowed a cut changes nothing.
- R4: An accepted sample with t_data < target - hyst, while ceil_m < abs_max, sets `ceil_m` to abs_max and leaves `mult` as it was.
- R5: An accepted sample with target - hyst <= t_data < target, while ceil_m < abs_max, raises `ceil_m` by one when mult == ceil_m and otherwise changes nothing.
- R6: A sample equal to zero, or a cycle with `t_valid` low, causes no thermal change to `mult` or `ceil_m`.
- R7: A hot cut when mult equals MIN_MULT leaves `mult` unchanged, raises no strobe, and sets `ceil_m` to MIN_MULT. The cut still uses up the interval.
- R8: With `req_valid` high, `mult` takes `req_mult` clamped to the range [MIN_MULT, ceil_m], where ceil_m is the value before the edge.
- R9: A thermal cut applied in the same cycle as a request wins, and the request is dropped. A cool or warm ceiling update does not block a request in the same cycle.
- R10: `mult_chg` is high for exactly the cycle in which the new `mult` value first appears, and only when that value differs from the previous one.
- R11: `t_ready` is high whenever `rst_n` is high. MIN_MULT <= mult <= ceil_m holds at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_valid | input | 1 | Temperature sample valid |
| t_ready | output | 1 | Sample accepted (high outside reset) |
| t_data | input | TW | Rounded signed temperature, 0 = invalid |
| target | input | TW | Signed target temperature |
| hyst | input | TW | Unsigned hysteresis |
| abs_max | input | MW | Absolute maximum multiplier |
| sec_tick | input | 1 | One-second interval pulse |
| req_valid | input | 1 | Multiplier change request |
| req_mult | input | MW | Requested multiplier |
| mult | output | MW | Current multiplier |
| ceil_m | output | MW | Current multiplier ceiling |
| mult_chg | output | 1 | One-cycle strobe on multiplier change |

## Verification
The bench builds the block with DEF_MULT set to 4 and leaves MIN_MULT at 1, RST_CEIL at 125 and the 8-bit widths at their defaults. With that reset multiplier, a short run of hot cuts reaches the floor, which makes the floor behaviour and the clamp against the reset ceiling both reachable. The bench drives `sec_tick` directly, so a tick can land in the same cycle as a hot sample. A negative temperature exercises the signed band comparison.

// File: rtl/thermal_gov_pkg.sv
package thermal_gov_pkg;
  typedef enum logic [1:0] {
    ZONE_NONE = 2'd0,
    ZONE_HOT  = 2'd1,
    ZONE_COOL = 2'd2,
    ZONE_WARM = 2'd3
  } zone_e;
endpackage

// File: rtl/thermal_gov_cls.sv
module thermal_gov_cls
  import thermal_gov_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          take,
  input  logic [TW-1:0] t_data,
  input  logic [TW-1:0] target,
  input  logic [TW-1:0] hyst,
  output zone_e         zone
);
  localparam int XW = TW + 2;

  logic signed [XW-1:0] tx, tg, hy, hi, lo;
  logic usable;

  always_comb begin
    tx = $signed({{2{t_data[TW-1]}}, t_data});
    tg = $signed({{2{target[TW-1]}}, target});
    hy = $signed({2'b00, hyst});
    hi = tg + hy;
    lo = tg - hy;
    usable = take && (t_data != '0);
    zone = ZONE_NONE;
    if (usable) begin
      if (tx > hi)      zone = ZONE_HOT;
      else if (tx < lo) zone = ZONE_COOL;
      else if (tx < tg) zone = ZONE_WARM;
    end
  end
endmodule

// File: rtl/thermal_gov_rate.sv
module thermal_gov_rate (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic cut,
  output logic allowed
);
  logic used;

  assign allowed = !used || sec_tick;

  always_ff @(posedge clk) begin
    if (!rst_n)        used <= 1'b0;
    else if (cut)      used <= 1'b1;
    else if (sec_tick) used <= 1'b0;
  end
endmodule

// File: rtl/thermal_gov_core.sv
module thermal_gov_core
  import thermal_gov_pkg::*;
#(
  parameter int MW       = 8,
  parameter int MIN_MULT = 1,
  parameter int DEF_MULT = 100,
  parameter int RST_CEIL = 125
) (
  input  logic          clk,
  input  logic          rst_n,
  input  zone_e         zone,
  input  logic          allowed,
  input  logic [MW-1:0] abs_max,
  input  logic          req_valid,
  input  logic [MW-1:0] req_mult,
  output logic          cut,
  output logic [MW-1:0] mult,
  output logic [MW-1:0] ceil_m,
  output logic          mult_chg
);
  localparam logic [MW-1:0] MINV = MW'(MIN_MULT);
  localparam logic [MW-1:0] DEFV = MW'(DEF_MULT);
  localparam logic [MW-1:0] CLV  = MW'(RST_CEIL);

  logic [MW-1:0] m_n, c_n, clamped;

  always_comb begin
    if (req_mult < MINV)        clamped = MINV;
    else if (req_mult > ceil_m) clamped = ceil_m;
    else                        clamped = req_mult;
  end

  always_comb begin
    m_n = mult;
    c_n = ceil_m;
    cut = 1'b0;
    if (zone == ZONE_HOT && allowed) begin
      cut = 1'b1;
      if (mult > MINV) m_n = mult - 1'b1;
      c_n = m_n;
    end else begin
      if (ceil_m < abs_max) begin
        if (zone == ZONE_COOL)
          c_n = abs_max;
        else if (zone == ZONE_WARM && mult == ceil_m)
          c_n = ceil_m + 1'b1;
      end
      if (req_valid) m_n = clamped;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mult     <= DEFV;
      ceil_m   <= CLV;
      mult_chg <= 1'b0;
    end else begin
      mult     <= m_n;
      ceil_m   <= c_n;
      mult_chg <= (m_n != mult);
    end
  end
endmodule

// File: rtl/thermal_gov.sv
module thermal_gov
  import thermal_gov_pkg::*;
#(
  parameter int TW       = 8,
  parameter int MW       = 8,
  parameter int MIN_MULT = 1,
  parameter int DEF_MULT = 100,
  parameter int RST_CEIL = 125
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          t_valid,
  output logic          t_ready,
  input  logic [TW-1:0] t_data,
  input  logic [TW-1:0] target,
  input  logic [TW-1:0] hyst,
  input  logic [MW-1:0] abs_max,
  input  logic          sec_tick,
  input  logic          req_valid,
  input  logic [MW-1:0] req_mult,
  output logic [MW-1:0] mult,
  output logic [MW-1:0] ceil_m,
  output logic          mult_chg
);
  zone_e zone;
  logic  allowed, cut;

  assign t_ready = rst_n;

  thermal_gov_cls #(.TW(TW)) u_cls (
    .take   (t_valid && t_ready),
    .t_data (t_data),
    .target (target),
    .hyst   (hyst),
    .zone   (zone)
  );

  thermal_gov_rate u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .cut      (cut),
    .allowed  (allowed)
  );

  thermal_gov_core #(
    .MW(MW), .MIN_MULT(MIN_MULT), .DEF_MULT(DEF_MULT), .RST_CEIL(RST_CEIL)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .zone      (zone),
    .allowed   (allowed),
    .abs_max   (abs_max),
    .req_valid (req_valid),
    .req_mult  (req_mult),
    .cut       (cut),
    .mult      (mult),
    .ceil_m    (ceil_m),
    .mult_chg  (mult_chg)
  );
endmodule

// File: rtl/thermal_gov_chk.sv
module thermal_gov_chk #(
  parameter int TW       = 8,
  parameter int MW       = 8,
  parameter int MIN_MULT = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          t_valid,
  input logic          t_ready,
  input logic [TW-1:0] t_data,
  input logic [TW-1:0] target,
  input logic [TW-1:0] hyst,
  input logic [MW-1:0] abs_max,
  input logic          req_valid,
  input logic [MW-1:0] mult,
  input logic [MW-1:0] ceil_m,
  input logic          mult_chg
);
  logic signed [TW+1:0] s_t, s_lo;
  assign s_t  = $signed({{2{t_data[TW-1]}}, t_data});
  assign s_lo = $signed({{2{target[TW-1]}}, target}) - $signed({2'b00, hyst});

  logic cold_take;
  assign cold_take = t_valid && t_ready && t_data != '0 && s_t < s_lo && ceil_m < abs_max;

  // R11: ready outside reset
  a_r11_ready: assert property (@(posedge clk) rst_n |-> t_ready);

  // R11: multiplier range
  a_r11_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mult >= MW'(MIN_MULT)) && (mult <= ceil_m));

  // R10: strobe matches a value change
  a_r10_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> (mult_chg == (mult != $past(mult))));

  // R4: cold sample restores ceiling
  a_r4_cool_restore: assert property (@(posedge clk) disable iff (!rst_n)
    cold_take |=> (ceil_m == $past(abs_max)));

  // R6: zero sample with no request changes nothing
  a_r6_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (t_data == '0 && !req_valid) |=> ($stable(mult) && $stable(ceil_m)));

  // R2: a fall of the multiplier without request leaves it at the ceiling
  a_r2_cut_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && $past(!req_valid) && mult < $past(mult)) |-> (ceil_m == mult));
endmodule

bind thermal_gov thermal_gov_chk #(.TW(TW), .MW(MW), .MIN_MULT(MIN_MULT)) u_chk (
  .clk(clk), .rst_n(rst_n), .t_valid(t_valid), .t_ready(t_ready), .t_data(t_data),
  .target(target), .hyst(hyst), .abs_max(abs_max), .req_valid(req_valid),
  .mult(mult), .ceil_m(ceil_m), .mult_chg(mult_chg)
);

// File: tb/thermal_gov_bench.sv
module thermal_gov_bench;
  localparam int TW = 8, MW = 8, MINM = 1, DEFM = 4, RCEIL = 125;

  logic clk = 0, rst_n = 0;
  logic t_valid = 0, sec_tick = 0, req_valid = 0;
  logic [TW-1:0] t_data = '0, target = 8'd50, hyst = 8'd5;
  logic [MW-1:0] abs_max = 8'd125, req_mult = '0;
  logic t_ready, mult_chg;
  logic [MW-1:0] mult, ceil_m;

  always #10 clk = ~clk;

  thermal_gov #(.TW(TW), .MW(MW), .MIN_MULT(MINM), .DEF_MULT(DEFM), .RST_CEIL(RCEIL)) u_thermal_gov (
    .clk(clk), .rst_n(rst_n), .t_valid(t_valid), .t_ready(t_ready), .t_data(t_data),
    .target(target), .hyst(hyst), .abs_max(abs_max), .sec_tick(sec_tick),
    .req_valid(req_valid), .req_mult(req_mult), .mult(mult), .ceil_m(ceil_m), .mult_chg(mult_chg)
  );

  typedef struct { int m; int c; bit s; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  int mm, mc; bit mused;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Reference model from the requirements, one cycle per call
  task automatic step(input bit tv, input int td, input bit tk, input bit rv, input int rm, input string tag);
    int t, nm, nc, rq; bit ok, cut;
    @(negedge clk); #1;
    t_valid = tv; t_data = TW'(td); sec_tick = tk; req_valid = rv; req_mult = MW'(rm);
    t = td; nm = mm; nc = mc; cut = 0;
    ok = tv && (td != 0);
    if (ok && t > 55 && (!mused || tk)) begin
      cut = 1;
      if (mm > MINM) nm = mm - 1;
      nc = nm;
    end else begin
      if (ok && mc < 125) begin
        if (t < 45) nc = 125;
        else if (t < 50 && mm == mc) nc = mc + 1;
      end
      if (rv) begin
        rq = rm;
        if (rq < MINM) rq = MINM; else if (rq > mc) rq = mc;
        nm = rq;
      end
    end
    if (cut) mused = 1; else if (tk) mused = 0;
    q.push_back('{nm, nc, (nm != mm), tag});
    mm = nm; mc = nc;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, int'(mult), e.m, "mult");
      chk(e.tag, int'(ceil_m), e.c, "ceil");
      chk(e.tag, int'(mult_chg), int'(e.s), "strobe");
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mm = DEFM; mc = RCEIL; mused = 0;
    repeat (3) @(negedge clk);
    chk("R1", int'(mult), DEFM, "reset mult");
    chk("R1", int'(ceil_m), RCEIL, "reset ceil");
    chk("R11", int'(t_ready), 0, "ready in reset");
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", int'(mult_chg), 0, "strobe after reset");
    chk("R11", int'(t_ready), 1, "ready");
    step(0, 0, 0, 1, 200, "R8 clamp high");
    step(0, 0, 0, 1, 0, "R8 clamp low");
    step(0, 0, 0, 1, 10, "R8 plain");
    step(0, 0, 0, 1, 10, "R10 same value");
    step(1, 60, 0, 0, 0, "R2 hot cut");
    step(1, 60, 0, 0, 0, "R3 limited");
    step(0, 0, 1, 0, 0, "R3 tick");
    step(1, 70, 0, 0, 0, "R3 new interval");
    step(1, 60, 1, 0, 0, "R3 tick same cycle");
    step(1, 60, 1, 0, 0, "R3 tick again");
    step(1, 0, 1, 0, 0, "R6 zero sample");
    step(0, 40, 1, 0, 0, "R6 not valid");
    step(1, 47, 0, 0, 0, "R5 creep");
    step(1, 47, 0, 0, 0, "R5 no creep");
    step(1, 52, 0, 0, 0, "R5 dead band");
    step(1, 40, 0, 0, 0, "R4 restore");
    step(0, 0, 0, 1, 2, "R8 down");
    step(1, 60, 1, 1, 50, "R9 cut wins");
    step(1, 60, 1, 0, 0, "R7 floor");
    step(1, 60, 1, 1, 9, "R7 floor with request");
    step(1, 60, 0, 1, 9, "R9 limited request");
    step(1, -20, 0, 1, 200, "R4 negative cold");
    step(1, 48, 0, 1, 125, "R9 warm and request");
    step(0, 0, 0, 0, 0, "R10 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule